// File: doc/BRIEF.md
# Two-Source Response Merger

This block joins two response producers into one ordered stream toward the host. One producer returns store completions. Each completion is a single word that reports the completion status, the memory tier and the page address of a stored page. The other producer returns load responses. Each load response is a packet of 65 words: one metadata word, then the 64 words of the page. Invalidation commands produce no responses, so only these two sources ever feed the merger.

The output is granted packet by packet in round-robin order. A load packet is an atomic burst: once its first word leaves, no store word may enter the stream until its 65th word has gone. Every port uses a valid/ready handshake. The output marks the final word of each packet and tags every word with its source. The block has no internal buffering: the selected source is wired through, and an output stall stalls that source.

Top module: `rsp_merge`

## Requirements
- R1: A store completion is packed into one output word as follows. Bits [PAGE_W-1:0] hold the page address. The next TIER_W bits hold the tier. The next STAT_W bits hold the status. All bits above them are zero.
- R2: Every store word leaves with out_last=1 and out_src=0.
- R3: A load packet leaves as 65 words carrying the input data unchanged, with out_src=1. out_last is 1 on the 65th word only.
- R4: Once the first word of a load packet has been transferred, no store word appears on the output until that packet's 65th word has been transferred.
- R5: While both sources keep requesting, completed packets alternate between store and load.
- R6: When only one source requests and out_ready stays high, its packets are served in consecutive cycles with no idle cycle.
- R7: While out_valid is high and out_ready is low, out_valid, out_data, out_last and out_src hold their values. No word is dropped or duplicated across a stall.
- R8: At most one of st_ready and ld_ready is high in any cycle, and neither is high while out_ready is low.
- R9: After reset, out_valid and both input readies are low while no source is valid. The first load word after reset is treated as a metadata word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store completion offered |
| st_ready | output | 1 | Store completion taken |
| st_status | input | STAT_W | Completion status |
| st_tier | input | TIER_W | Memory tier of the stored page |
| st_page | input | PAGE_W | Remote page address |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word taken |
| ld_data | input | DATA_W | Load word (metadata or page content) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Host accepts the output word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final word of a packet |
| out_src | output | 1 | 0 = store completion, 1 = load packet |

## Verification
Two things can happen in the same cycle. A store completion can arrive just as a load packet sends its final word, and a load packet can become ready just as a store word is accepted. In both cases the arbiter must finish one packet and hand the grant to the other source at once. The bench provokes this by running the store and load drivers concurrently and back to back, first with a steady out_ready and then with pseudo-random stalls. The scoreboard compares every word against per-source queues. The order in which packets complete is logged and must alternate, and no store word may fall inside a load burst.

// File: rtl/rsp_merge_pkg.sv
package rsp_merge_pkg;
    typedef enum logic {
        SRC_ST = 1'b0,
        SRC_LD = 1'b1
    } src_e;
endpackage

// File: rtl/rsp_merge_stpack.sv
module rsp_merge_stpack #(
    parameter int DATA_W = 64,
    parameter int PAGE_W = 36,
    parameter int TIER_W = 2,
    parameter int STAT_W = 3
) (
    input  logic [STAT_W-1:0] status,
    input  logic [TIER_W-1:0] tier,
    input  logic [PAGE_W-1:0] page,
    output logic [DATA_W-1:0] word
);
    localparam int USED_W = PAGE_W + TIER_W + STAT_W;
    localparam int PAD_W  = DATA_W - USED_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, status, tier, page};
        end else begin : g_nopad
            assign word = {status, tier, page};
        end
    endgenerate
endmodule

// File: rtl/rsp_merge_ldframe.sv
module rsp_merge_ldframe #(
    parameter int PKT_WORDS = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    output logic last_beat
);
    localparam int CW = $clog2(PKT_WORDS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } fr_t;

    fr_t q, d;

    assign last_beat = (q.cnt == CW'(PKT_WORDS - 1));

    always_comb begin
        d = q;
        if (beat) begin
            if (last_beat) d.cnt = '0;
            else           d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3
    ldf_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(PKT_WORDS - 1));

    // R3
    ldf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last_beat) |=> (q.cnt == '0));
endmodule

// File: rtl/rsp_merge_arb.sv
module rsp_merge_arb
    import rsp_merge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic st_req,
    input  logic ld_req,
    input  logic xfer,
    input  logic pkt_end,
    output src_e sel,
    output logic sel_vld
);
    typedef struct packed {
        logic busy;
        src_e owner;
        src_e prio;
    } arb_t;

    arb_t q, d;
    src_e pick;
    logic pick_req;

    always_comb begin
        d = q;
        if (q.busy)                pick = q.owner;
        else if (st_req && ld_req) pick = q.prio;
        else if (ld_req)           pick = SRC_LD;
        else                       pick = SRC_ST;
        pick_req = (pick == SRC_LD) ? ld_req : st_req;
        if (pick_req) begin
            if (xfer && pkt_end) begin
                d.busy = 1'b0;
                d.prio = (pick == SRC_LD) ? SRC_ST : SRC_LD;
            end else begin
                d.busy  = 1'b1;
                d.owner = pick;
            end
        end
    end

    assign sel     = pick;
    assign sel_vld = pick_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.busy  <= 1'b0;
            q.owner <= SRC_ST;
            q.prio  <= SRC_ST;
        end else begin
            q <= d;
        end
    end

    // R4
    arb_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && sel == SRC_LD && xfer && !pkt_end) |=> (sel == SRC_LD));

    // R5
    arb_rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && xfer && pkt_end && st_req && ld_req)
        |=> (!(st_req && ld_req) || sel != $past(sel)));
endmodule

// File: rtl/rsp_merge.sv
module rsp_merge
    import rsp_merge_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int PAGE_W    = 36,
    parameter int TIER_W    = 2,
    parameter int STAT_W    = 3,
    parameter int PAGE_WRDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [STAT_W-1:0] st_status,
    input  logic [TIER_W-1:0] st_tier,
    input  logic [PAGE_W-1:0] st_page,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [DATA_W-1:0] ld_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_src
);
    localparam int PKT_WORDS = PAGE_WRDS + 1;

    logic [DATA_W-1:0] st_word;
    logic              ld_last;
    logic              ld_beat;
    logic              xfer;
    src_e              sel;
    logic              sel_vld;

    rsp_merge_stpack #(
        .DATA_W(DATA_W), .PAGE_W(PAGE_W), .TIER_W(TIER_W), .STAT_W(STAT_W)
    ) u_pack (
        .status(st_status), .tier(st_tier), .page(st_page), .word(st_word)
    );

    rsp_merge_ldframe #(.PKT_WORDS(PKT_WORDS)) u_frame (
        .clk(clk), .rst_n(rst_n), .beat(ld_beat), .last_beat(ld_last)
    );

    rsp_merge_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .st_req(st_valid), .ld_req(ld_valid),
        .xfer(xfer), .pkt_end(out_last),
        .sel(sel), .sel_vld(sel_vld)
    );

    assign out_valid = sel_vld;
    assign out_src   = sel;
    assign out_data  = (sel == SRC_LD) ? ld_data : st_word;
    assign out_last  = (sel == SRC_LD) ? ld_last : 1'b1;
    assign xfer      = out_valid && out_ready;
    assign st_ready  = out_ready && sel_vld && (sel == SRC_ST);
    assign ld_ready  = out_ready && sel_vld && (sel == SRC_LD);
    assign ld_beat   = ld_valid && ld_ready;

    logic mid_ld_d, mid_ld_q;
    always_comb begin
        mid_ld_d = mid_ld_q;
        if (xfer && out_src) mid_ld_d = !out_last;
    end
    always_ff @(posedge clk) begin
        if (!rst_n) mid_ld_q <= 1'b0;
        else        mid_ld_q <= mid_ld_d;
    end

    // R2
    st_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_src) |-> out_last);

    // R4
    no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_ld_q |-> !(out_valid && !out_src));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_src)));

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_ready, ld_ready}) && (out_ready || !(st_ready || ld_ready)));
endmodule

// File: tb/rsp_merge_test.sv
`timescale 1ns/1ps
module rsp_merge_test;
    localparam int DATA_W = 64, PAGE_W = 36, TIER_W = 2, STAT_W = 3, PW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0, ld_valid = 1'b0, out_ready = 1'b1;
    logic st_ready, ld_ready, out_valid, out_last, out_src;
    logic [STAT_W-1:0] st_status = '0;
    logic [TIER_W-1:0] st_tier = '0;
    logic [PAGE_W-1:0] st_page = '0;
    logic [DATA_W-1:0] ld_data = '0;
    logic [DATA_W-1:0] out_data;

    always #2.5 clk = ~clk;

    rsp_merge uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_status(st_status), .st_tier(st_tier), .st_page(st_page),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .out_src(out_src)
    );

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0, rnd = 0;
    logic [DATA_W:0] st_q[$];
    logic [DATA_W:0] ld_q[$];
    logic plog[512];
    int pcnt = 0;
    int scyc[64];
    int scnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req,
                       input logic [DATA_W:0] act, input logic [DATA_W:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ready driver
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = rnd ? (lfsr[0] | lfsr[3]) : 1'b1;
        end
    end

    // monitor / scoreboard
    initial begin
        bit mid_ld = 0;
        bit pv = 0;
        logic [DATA_W+1:0] prev = '0;
        logic [DATA_W:0] e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                // R8
                if (st_ready && ld_ready)
                    chk(0, "R8 both readies", 1, 0);
                if (!out_ready && (st_ready || ld_ready))
                    chk(0, "R8 ready while stalled", 1, 0);
                // R7 hold across stall
                if (pv) chk(out_valid && {out_src, out_last, out_data} == prev,
                            "R7 hold", {out_last, out_data}, prev[DATA_W:0]);
                pv = out_valid && !out_ready;
                prev = {out_src, out_last, out_data};
                if (out_valid && out_ready) begin
                    if (!out_src) begin
                        // R4
                        if (mid_ld) chk(0, "R4 store inside load", 1, 0);
                        if (st_q.size() == 0) chk(0, "R7 extra store word", {out_last, out_data}, 0);
                        else begin
                            e = st_q.pop_front();
                            chk({out_last, out_data} == e, "R1 R2 store word", {out_last, out_data}, e);
                        end
                        scyc[scnt % 64] = cyc; scnt++;
                    end else begin
                        if (ld_q.size() == 0) chk(0, "R7 extra load word", {out_last, out_data}, 0);
                        else begin
                            e = ld_q.pop_front();
                            chk({out_last, out_data} == e, "R3 load word", {out_last, out_data}, e);
                        end
                        mid_ld = !out_last;
                    end
                    if (out_last) begin plog[pcnt % 512] = out_src; pcnt++; end
                end
            end
        end
    end

    task automatic send_store(input logic [STAT_W-1:0] s, input logic [TIER_W-1:0] t,
                              input logic [PAGE_W-1:0] p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PAGE_W-1:0] = p;
        w[PAGE_W +: TIER_W] = t;
        w[PAGE_W+TIER_W +: STAT_W] = s;
        st_q.push_back({1'b1, w});
        st_valid = 1; st_status = s; st_tier = t; st_page = p;
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #1;
        st_valid = 0;
    endtask

    task automatic send_load(input logic [15:0] id);
        for (int k = 0; k <= PW; k++)
            ld_q.push_back({(k == PW), (k == 0) ? {16'hBEEF, id, 32'h0} : {id, 16'h0, 32'(k * 7 + 1)}});
        for (int k = 0; k <= PW; k++) begin
            ld_valid = 1;
            ld_data = (k == 0) ? {16'hBEEF, id, 32'h0} : {id, 16'h0, 32'(k * 7 + 1)};
            do @(negedge clk); while (!ld_ready);
            @(posedge clk); #1;
        end
        ld_valid = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int b;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(!out_valid, "R9 out_valid after reset", out_valid, 0);
        chk(!st_ready && !ld_ready, "R9 readies after reset", {st_ready, ld_ready}, 0);
        @(posedge clk); #1;

        // R6 back-to-back stores, R1 field packing
        b = scnt;
        send_store(3'd5, 2'd2, 36'h9_1234_5678);
        send_store(3'd7, 2'd3, 36'hF_FFFF_FFFF);
        send_store(3'd0, 2'd1, 36'h0_0000_0001);
        send_store(3'd2, 2'd0, 36'hA_5A5A_5A5A);
        for (int i = 1; i < 4; i++)
            chk(scyc[(b + i) % 64] == scyc[(b + i - 1) % 64] + 1, "R6 back-to-back",
                scyc[(b + i) % 64], scyc[(b + i - 1) % 64] + 1);

        // R3 and R9: first load after reset framed from its metadata word
        send_load(16'h0001);
        repeat (2) @(posedge clk); #1;

        // R5 both sources continuously requesting
        b = pcnt;
        fork
            for (int i = 0; i < 3; i++) send_store(3'(i + 1), 2'(i), 36'(i * 4096 + 17));
            for (int i = 0; i < 3; i++) send_load(16'(16 + i));
        join
        for (int i = 1; i < 6; i++)
            chk(plog[(b + i) % 512] != plog[(b + i - 1) % 512], "R5 alternation",
                plog[(b + i) % 512], !plog[(b + i - 1) % 512]);

        // R7 random stalls with contention
        rnd = 1;
        fork
            for (int i = 0; i < 5; i++) send_store(3'(i), 2'(3 - (i % 4)), 36'(i * 999 + 3));
            for (int i = 0; i < 3; i++) send_load(16'(32 + i));
        join
        rnd = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(st_q.size() == 0, "R7 store words lost", st_q.size(), 0);
        chk(ld_q.size() == 0, "R7 load words lost", ld_q.size(), 0);
        chk(!out_valid, "R9 idle output", out_valid, 0);
        finish_run();
    end
endmodule